// File: doc/BRIEF.md
# Period-Synchronous PWM Generator

This block turns an unsigned W-bit duty word into a single pulse-width-modulated output whose period is 2^W clock cycles. A free-running W-bit counter sweeps every value once per period. The output is held by a set/reset latch: the latch is set when the counter wraps from its top value back to zero, and it is cleared when the counter reaches the registered duty value. The output is therefore high for exactly `duty` cycles at the start of each period, which gives a duty cycle of duty / 2^W. The resolution is one part in 2^W: 1.56 % at W = 6, 0.78 % at W = 7 and 0.39 % at W = 8.

The duty word usually comes straight from a host's output port and may change at any time. The block copies it into a shadow register only in the last cycle of a period, so a change always takes effect at a period boundary and never shortens or stretches the period in progress. A one-cycle strobe marks the first cycle of every period, so the host knows when it may safely prepare the next value.

The clear comparator looks one cycle ahead. It compares the counter's next value with the duty value that will be in force after the coming edge. The latch can then register its output without an extra cycle of lag, and set and clear can be resolved in the same edge.

Top module: `pwm_period_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, `pwm_out` and `period_start` are 0. The counter and the shadow duty register restart from 0, so the whole first period after reset is low.
- R2: `period_start` pulses exactly once every 2^W clock cycles.
- R3: For a registered duty value d (the duty word read as an unsigned integer), `pwm_out` is high in cycle k of a period (k = 0 .. 2^W-1, where k = 0 is the `period_start` cycle) exactly when k < d. The high time is therefore d cycles in one contiguous run.
- R4: A duty value of 0 keeps `pwm_out` low for the whole period. Where the set and the clear coincide, the clear wins.
- R5: With the largest duty value, 2^W-1, `pwm_out` is high for 2^W-1 cycles and low only in the last cycle of the period. The output is never high in the last cycle of any period.
- R6: `duty_word` is sampled only at the clock edge that ends a period, that is, the edge where the counter leaves 2^W-1. Its value at any other edge has no effect on the output.
- R7: `period_start` is one cycle wide and is high only in cycle 0 of a period. It is not raised in the first period after reset.
- R8: `pwm_out` rises only in a cycle where `period_start` is high, so it has no mid-period rising glitch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| duty_word | input | W | Requested duty as an unsigned count of high cycles per period |
| pwm_out | output | 1 | Modulated output, driven from the set/reset latch |
| period_start | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
The hardest situation to reach is a duty word that changes in the middle of a period. The change must be ignored until the wrap, and the value present at that one sampling edge must be the one that takes effect. The stimulus writes random values at random points inside some periods and then places the intended value only in the last cycle. It also writes junk in the cycle just after a boundary, so that any early sampling or any extra sampling edge shows up as a wrong high time. Directed periods cover the duty values 0, 1 and 2^W-1, where set and clear meet at the wrap, and a reset in the middle of a high phase.

// File: rtl/pwm_period_pkg.sv
package pwm_period_pkg;

  // Action applied to the output latch at the next edge.
  typedef enum logic [1:0] {
    LA_HOLD  = 2'd0,
    LA_SET   = 2'd1,
    LA_CLEAR = 2'd2
  } latch_act_e;

  // Next counter value, wrapping at 2^w (w up to 31).
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (v + 32'd1) & mask;
  endfunction

  // Latch decision: a clear request beats a set request.
  function automatic latch_act_e latch_decide(input logic set_req, input logic clr_req);
    if (clr_req)      return LA_CLEAR;
    else if (set_req) return LA_SET;
    else              return LA_HOLD;
  endfunction

endpackage

// File: rtl/pwm_count.sv
module pwm_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         last
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_comb begin
    cnt_nxt = W'(pwm_period_pkg::wrap_inc(32'(cnt), W));
    last    = (cnt == TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_q,
  output logic [W-1:0] d_nxt
);
  always_comb d_nxt = load ? d_in : d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= '0;
    else     d_q <= d_nxt;
  end
endmodule

// File: rtl/pwm_latch.sv
module pwm_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic start_req,
  output logic level,
  output logic strobe
);
  import pwm_period_pkg::*;

  latch_act_e act;

  always_comb act = latch_decide(set_req, clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      level  <= 1'b0;
      strobe <= 1'b0;
    end else begin
      strobe <= start_req;
      case (act)
        LA_SET:   level <= 1'b1;
        LA_CLEAR: level <= 1'b0;
        default:  level <= level;
      endcase
    end
  end
endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] duty_word,
  output logic         pwm_out,
  output logic         period_start
);
  // Named internal events, visible to the bound checker.
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;
  logic         wrap;
  logic [W-1:0] duty_q;
  logic [W-1:0] duty_nxt;
  logic         hit;

  pwm_count #(.W(W)) count_i (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .last    (wrap)
  );

  pwm_shadow #(.W(W)) shadow_i (
    .clk   (clk),
    .rst   (rst),
    .load  (wrap),
    .d_in  (duty_word),
    .d_q   (duty_q),
    .d_nxt (duty_nxt)
  );

  // Look-ahead equality: the count and duty in force after this edge.
  always_comb hit = (cnt_nxt == duty_nxt);

  pwm_latch latch_i (
    .clk       (clk),
    .rst       (rst),
    .set_req   (wrap),
    .clr_req   (hit),
    .start_req (wrap),
    .level     (pwm_out),
    .strobe    (period_start)
  );
endmodule

// File: rtl/pwm_period_gen_chk.sv
module pwm_period_gen_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         pwm_out,
  input logic         period_start,
  input logic [W-1:0] cnt,
  input logic         wrap,
  input logic [W-1:0] duty_q
);
  localparam int unsigned PERIOD = 1 << W;

  logic [W:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (period_start) begin
      gap  <= (W+1)'(1);
      seen <= 1'b1;
    end else begin
      gap  <= gap + (W+1)'(1);
    end
  end

  // R2: strobes exactly one period apart
  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    (period_start && seen) |-> (32'(gap) == PERIOD));

  // R7: strobe is one cycle wide
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  // R8: rising output only at a period start
  a_r8_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> period_start);

  // R3: output falls exactly when the count reaches the duty value
  a_r3_fall_at_match: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_out) |-> (cnt == duty_q));

  // R4: zero duty gives no high cycle at the period start
  a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
    (period_start && duty_q == '0) |-> !pwm_out);

  // R5: never high in the last cycle of a period
  a_r5_low_at_end: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !pwm_out);

  // R6: shadow duty only changes across a wrap edge
  a_r6_duty_hold: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(duty_q));
endmodule

bind pwm_period_gen pwm_period_gen_chk #(.W(W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .pwm_out      (pwm_out),
  .period_start (period_start),
  .cnt          (cnt),
  .wrap         (wrap),
  .duty_q       (duty_q)
);

// File: tb/pwm_period_gen_tb_top.sv
module pwm_period_gen_tb_top;
  localparam int W = 8;
  localparam int P = 1 << W;
  localparam int MAXD = P - 1;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] duty_word;
  logic         pwm_out;
  logic         period_start;

  int n_cmp = 0;
  int n_bad = 0;
  int cur_d = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_period_gen #(.W(W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .duty_word    (duty_word),
    .pwm_out      (pwm_out),
    .period_start (period_start)
  );

  function automatic int exp_level(input int pos, input int d);
    return (pos < d) ? 1 : 0;
  endfunction

  function automatic int exp_strobe(input int pos, input bit after_first);
    return (pos == 0 && after_first) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic string level_tag(input int d, input bit junk);
    if (junk)      return "R6 level under mid-period writes";
    if (d == 0)    return "R4 zero duty level";
    if (d == MAXD) return "R5 full duty level";
    return "R3 level";
  endfunction

  // One period: check every cycle, load target at the last cycle.
  task automatic run_period(input int target, input bit junk);
    int hi = 0;
    int prev = pwm_out;
    for (int pos = 0; pos < P; pos++) begin
      chk(level_tag(cur_d, junk), int'(pwm_out), exp_level(pos, cur_d));
      chk(pos == 0 ? "R2 strobe at period start" : "R7 strobe width",
          int'(period_start), exp_strobe(pos, started));
      if (pwm_out && !prev) chk("R8 rise position", pos, 0);
      if (pwm_out) hi++;
      prev = pwm_out;
      if (pos == P - 1)
        duty_word = W'(target);
      else if (junk && (pos == 0 || pos == P - 2 || ($urandom % 8) == 0))
        duty_word = W'($urandom);
      @(negedge clk);
    end
    chk(junk ? "R6 high time" : "R3 high time", hi, cur_d);
    cur_d = target;
    started = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    duty_word = '0;
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm_out), 0);
    chk("R1 strobe in reset", int'(period_start), 0);
    duty_word = W'(77);
    rst = 1'b0;
    // First period: shadow is 0, so all low (R1)
    run_period(0, 1'b0);
    run_period(MAXD, 1'b0);
    run_period(1, 1'b0);
    run_period(128, 1'b0);
    run_period(MAXD - 1, 1'b0);
    run_period(0, 1'b0);
    run_period(200, 1'b1);
    run_period(3, 1'b1);
    run_period(MAXD, 1'b1);
    run_period(0, 1'b1);
    for (int i = 0; i < 14; i++)
      run_period(int'($urandom % P), (i % 2) == 1);

    // Reset in the middle of a high phase (cur_d is 200 next)
    run_period(200, 1'b0);
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 pwm after mid-run reset", int'(pwm_out), 0);
    chk("R1 strobe after mid-run reset", int'(period_start), 0);
    @(negedge clk);
    duty_word = W'(99);
    rst = 1'b0;
    cur_d = 0;
    started = 1'b0;
    run_period(60, 1'b1);
    run_period(MAXD, 1'b0);
    run_period(17, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule